// File: doc/BRIEF.md
# Saturating Add/Subtract Unit with Status Flags

This block is the clamping arithmetic stage of a processor datapath. It takes a destination operand, a source operand and a short immediate. It performs one of four signed operations: add, subtract, reverse subtract, or subtract of the sign-extended immediate. When the exact signed result falls outside the 32-bit range, the block replaces it with the nearest representable extreme.

Alongside the clamped result it keeps a five-bit status word. That word holds zero, sign, overflow, carry/borrow and a sticky saturation bit. Carry and overflow describe the raw, unclamped operation. Sign and zero describe the value actually delivered.

Software can load the whole status word directly. This is how the sticky saturation bit is cleared. A direct load wins over the flag update of an operation issued in the same cycle. Results and flags are registered and appear one cycle after the request, together with a one-cycle done pulse.

Top module: `clamp_arith_unit`

## Requirements
- R1: With `op_sel` = 0 the unit computes `dst_val + src_val`. When no clamping occurs, the result is the exact 32-bit sum.
- R2: With `op_sel` = 1 the unit computes `dst_val - src_val`.
- R3: With `op_sel` = 2 the unit computes `src_val - dst_val` (reverse subtract).
- R4: With `op_sel` = 3 the unit computes `dst_val` minus `imm_val` sign-extended from 16 to 32 bits.
- R5: If the exact signed result exceeds the positive limit, the result is 0x7FFFFFFF. If it falls below the negative limit, the result is 0x80000000. Either clamp sets both the overflow bit (status bit 2) and the saturation bit (status bit 4).
- R6: A result that lands exactly on 0x7FFFFFFF or 0x80000000 without overflow leaves overflow clear and adds nothing to saturation.
- R7: The carry bit (status bit 3) comes from the raw operation. For an add it is the unsigned carry out. For any subtract it is the borrow, meaning the minuend is below the subtrahend when both are read as unsigned.
- R8: The zero bit (status bit 0) and the sign bit (status bit 1) are computed from the clamped result.
- R9: Once set, the saturation bit stays set through later non-clamping operations. It is cleared only by a status load.
- R10: When `flag_wr` is high, all five status bits take `flag_wr_data` on the next edge. Bit 0 is zero, bit 1 sign, bit 2 overflow, bit 3 carry and bit 4 saturation. This load has priority over the flag update of a simultaneous operation; that operation's result is still delivered.
- R11: After reset, `result`, `flags` and `done` are all zero. Each accepted operation updates `result` and `flags` on the next clock edge, and `done` is high for exactly that cycle. Without a request, `result` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Request strobe: perform the selected operation this cycle |
| op_sel | input | 2 | Operation code: 0 add, 1 sub, 2 reverse sub, 3 immediate sub |
| dst_val | input | 32 | Destination-register operand |
| src_val | input | 32 | Source-register operand |
| imm_val | input | 16 | Signed immediate for operation 3 |
| flag_wr | input | 1 | Load the status word directly |
| flag_wr_data | input | 5 | Value loaded into the status word |
| result | output | 32 | Registered clamped result |
| flags | output | 5 | Registered status word {sat, carry, ovf, sign, zero} |
| done | output | 1 | One-cycle pulse marking new result and flags |

## Verification
Every output of this unit is due exactly one rising edge after the inputs that produce it. The bench drives stimulus on the falling edge and advances its behavioural model on the rising edge. It compares `result`, `flags` and `done` against that model on the following falling edge, every cycle.

The directed cases use the same slot. The bench issues an operation, waits one falling edge, and then compares against hand-derived constants. The sticky saturation bit and the priority of a status load are checked the same way, on the cycle right after the request that touches them.

// File: rtl/clamp_arith_pkg.sv
package clamp_arith_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_SUB  = 2'd1,
    OP_RSUB = 2'd2,
    OP_SUBI = 2'd3
  } arith_op_e;

  // status word bit positions (decoded by branch logic downstream)
  localparam int FL_ZERO  = 0;
  localparam int FL_SIGN  = 1;
  localparam int FL_OVF   = 2;
  localparam int FL_CARRY = 3;
  localparam int FL_SAT   = 4;
  localparam int FL_W     = 5;

endpackage

// File: rtl/clamp_arith_core.sv
module clamp_arith_core
  import clamp_arith_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 16
) (
  input  arith_op_e        op,
  input  logic [W-1:0]     dst,
  input  logic [W-1:0]     src,
  input  logic [IMM_W-1:0] imm,
  output logic [W-1:0]     clamped,
  output logic             carry,
  output logic             ovf
);

  localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] imm_ext;

  generate
    if (IMM_W < W) begin : g_imm_widen
      assign imm_ext = {{(W-IMM_W){imm[IMM_W-1]}}, imm};
    end else begin : g_imm_trunc
      assign imm_ext = imm[W-1:0];
    end
  endgenerate

  // raw adder with an extra bit for carry-out
  function automatic logic [W:0] raw_op(input logic [W-1:0] a,
                                        input logic [W-1:0] b,
                                        input logic         sub);
    logic [W:0] r;
    if (sub) r = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, 1'b1};
    else     r = {1'b0, a} + {1'b0, b};
    return r;
  endfunction

  // signed overflow from operand and raw-result sign bits
  function automatic logic ovf_of(input logic sa, input logic sb,
                                  input logic sr, input logic sub);
    logic same_in;
    same_in = sub ? (sa != sb) : (sa == sb);
    return same_in && (sr != sa);
  endfunction

  logic [W-1:0] opa, opb;
  logic         is_sub;
  logic [W:0]   raw;

  always_comb begin
    opa    = dst;
    opb    = src;
    is_sub = 1'b1;
    unique case (op)
      OP_ADD:  begin opa = dst; opb = src;     is_sub = 1'b0; end
      OP_SUB:  begin opa = dst; opb = src;     end
      OP_RSUB: begin opa = src; opb = dst;     end
      OP_SUBI: begin opa = dst; opb = imm_ext; end
      default: begin opa = dst; opb = src;     end
    endcase
  end

  always_comb begin
    raw   = raw_op(opa, opb, is_sub);
    carry = is_sub ? ~raw[W] : raw[W];
    ovf   = ovf_of(opa[W-1], opb[W-1], raw[W-1], is_sub);
    if (ovf) clamped = opa[W-1] ? NEG_LIM : POS_LIM;
    else     clamped = raw[W-1:0];
  end

endmodule

// File: rtl/clamp_arith_flags.sv
module clamp_arith_flags
  import clamp_arith_pkg::*;
#(
  parameter int W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd,
  input  logic            wr,
  input  logic [FL_W-1:0] wr_data,
  input  logic [W-1:0]    res_next,
  input  logic            carry,
  input  logic            ovf,
  output logic [FL_W-1:0] flags
);

  logic [FL_W-1:0] op_flags;

  always_comb begin
    op_flags           = '0;
    op_flags[FL_ZERO]  = (res_next == '0);
    op_flags[FL_SIGN]  = res_next[W-1];
    op_flags[FL_OVF]   = ovf;
    op_flags[FL_CARRY] = carry;
    op_flags[FL_SAT]   = flags[FL_SAT] | ovf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flags <= '0;
    else if (wr)  flags <= wr_data;
    else if (upd) flags <= op_flags;
  end

endmodule

// File: rtl/clamp_arith_unit.sv
module clamp_arith_unit
  import clamp_arith_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [1:0]       op_sel,
  input  logic [W-1:0]     dst_val,
  input  logic [W-1:0]     src_val,
  input  logic [IMM_W-1:0] imm_val,
  input  logic             flag_wr,
  input  logic [FL_W-1:0]  flag_wr_data,
  output logic [W-1:0]     result,
  output logic [FL_W-1:0]  flags,
  output logic             done
);

  logic [W-1:0] core_res;
  logic         core_carry;
  logic         core_ovf;

  clamp_arith_core #(.W(W), .IMM_W(IMM_W)) u_core (
    .op      (arith_op_e'(op_sel)),
    .dst     (dst_val),
    .src     (src_val),
    .imm     (imm_val),
    .clamped (core_res),
    .carry   (core_carry),
    .ovf     (core_ovf)
  );

  clamp_arith_flags #(.W(W)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd      (op_valid),
    .wr       (flag_wr),
    .wr_data  (flag_wr_data),
    .res_next (core_res),
    .carry    (core_carry),
    .ovf      (core_ovf),
    .flags    (flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= op_valid;
      if (op_valid) result <= core_res;
    end
  end

endmodule

// File: rtl/clamp_arith_chk.sv
module clamp_arith_chk
  import clamp_arith_pkg::*;
#(
  parameter int W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_valid,
  input logic            flag_wr,
  input logic [FL_W-1:0] flag_wr_data,
  input logic            core_ovf,
  input logic [W-1:0]    result,
  input logic [FL_W-1:0] flags,
  input logic            done
);

  localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

  AST_CLAMP_SETS_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !flag_wr && core_ovf |=> flags[FL_SAT] && flags[FL_OVF] && (result == POS_LIM || result == NEG_LIM)); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !flag_wr && !core_ovf |=> !flags[FL_OVF]); // R6

  AST_ZERO_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !flag_wr |=> flags[FL_ZERO] == (result == '0) && flags[FL_SIGN] == result[W-1]); // R8

  AST_SAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flags[FL_SAT] && !flag_wr |=> flags[FL_SAT]); // R9

  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    flag_wr |=> flags == $past(flag_wr_data)); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> done); // R11

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !done && $stable(result)); // R11

endmodule

bind clamp_arith_unit clamp_arith_chk #(.W(W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .op_valid     (op_valid),
  .flag_wr      (flag_wr),
  .flag_wr_data (flag_wr_data),
  .core_ovf     (core_ovf),
  .result       (result),
  .flags        (flags),
  .done         (done)
);

// File: tb/clamp_arith_unit_test.sv
module clamp_arith_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_sel = 2'd0;
  logic [31:0] dst_val = '0;
  logic [31:0] src_val = '0;
  logic [15:0] imm_val = '0;
  logic        flag_wr = 1'b0;
  logic [4:0]  flag_wr_data = '0;
  logic [31:0] result;
  logic [4:0]  flags;
  logic        done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string cur_req = "R11";
  string exp_req = "R11";

  // reference model state
  logic [31:0] m_res = '0;
  logic [4:0]  m_flg = '0;
  logic        m_done = 1'b0;

  always #5 clk = ~clk;

  clamp_arith_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .dst_val(dst_val), .src_val(src_val), .imm_val(imm_val),
    .flag_wr(flag_wr), .flag_wr_data(flag_wr_data),
    .result(result), .flags(flags), .done(done)
  );

  // behavioural model from the requirements: exact math in 64-bit integers
  task automatic model_op(output logic [31:0] r, output logic [4:0] f);
    longint a, b, exact;
    longint unsigned ua, ub;
    int bi;
    bit sub, c, v;
    bi = $signed(imm_val);
    case (op_sel)
      2'd0: begin a = $signed(dst_val); b = $signed(src_val); ua = dst_val; ub = src_val; sub = 0; end
      2'd1: begin a = $signed(dst_val); b = $signed(src_val); ua = dst_val; ub = src_val; sub = 1; end
      2'd2: begin a = $signed(src_val); b = $signed(dst_val); ua = src_val; ub = dst_val; sub = 1; end
      default: begin a = $signed(dst_val); b = bi; ua = dst_val; ub = 32'(bi); sub = 1; end
    endcase
    exact = sub ? a - b : a + b;
    c = sub ? (ua < ub) : ((ua + ub) > 64'hFFFF_FFFF);
    v = 1'b0;
    if (exact > 64'sd2147483647)       begin r = 32'h7FFF_FFFF; v = 1'b1; end
    else if (exact < -64'sd2147483648) begin r = 32'h8000_0000; v = 1'b1; end
    else r = exact[31:0];
    f = {m_flg[4] | v, c, v, r[31], r == 32'd0};
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_res = '0; m_flg = '0; m_done = 1'b0;
    end else begin
      logic [31:0] r;
      logic [4:0]  f;
      m_done = op_valid;
      if (op_valid) begin
        model_op(r, f);
        m_res = r;
        if (!flag_wr) m_flg = f;
      end
      if (flag_wr) m_flg = flag_wr_data;
      if (op_valid || flag_wr) exp_req = cur_req;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (result !== m_res || flags !== m_flg || done !== m_done) begin
        errors++;
        $display("FAIL %s model: result %h flags %b done %b, expected %h %b %b",
                 exp_req, result, flags, done, m_res, m_flg, m_done);
      end
    end
  end

  task automatic check_out(input string req, input logic [31:0] er, input logic [4:0] ef);
    checks++;
    if (result !== er || flags !== ef) begin
      errors++;
      $display("FAIL %s: result %h flags %b, expected %h %b", req, result, flags, er, ef);
    end
  endtask

  // drive at a falling edge, outputs due at the next falling edge
  task automatic do_op(input string req, input logic [1:0] op, input logic [31:0] d,
                       input logic [31:0] s, input logic [15:0] im);
    cur_req = req;
    op_sel = op; dst_val = d; src_val = s; imm_val = im; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic load_flags(input string req, input logic [4:0] v);
    cur_req = req;
    flag_wr = 1'b1; flag_wr_data = v;
    @(negedge clk);
    flag_wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (result !== 32'd0 || flags !== 5'd0 || done !== 1'b0) begin
      errors++;
      $display("FAIL R11 reset: %h %b %b, expected 0 0 0", result, flags, done);
    end
    rst_n = 1'b1;
    @(negedge clk);

    do_op("R1", 2'd0, 32'd5, 32'd7, 16'd0);                    check_out("R1", 32'd12, 5'b00000);
    do_op("R5", 2'd0, 32'h7000_0000, 32'h7000_0000, 16'd0);    check_out("R5", 32'h7FFF_FFFF, 5'b10100);
    do_op("R9", 2'd0, 32'd1, 32'd2, 16'd0);                    check_out("R9", 32'd3, 5'b10000);
    do_op("R9", 2'd1, 32'd2, 32'd1, 16'd0);                    check_out("R9", 32'd1, 5'b10000);
    load_flags("R10", 5'b00000);                               check_out("R10", 32'd1, 5'b00000);
    do_op("R9", 2'd0, 32'd1, 32'd2, 16'd0);                    check_out("R9", 32'd3, 5'b00000);
    do_op("R6", 2'd0, 32'h7000_0000, 32'h0FFF_FFFF, 16'd0);    check_out("R6", 32'h7FFF_FFFF, 5'b00000);
    do_op("R6", 2'd0, 32'h9000_0000, 32'hF000_0000, 16'd0);    check_out("R6", 32'h8000_0000, 5'b01010);
    do_op("R7", 2'd0, 32'h9000_0000, 32'h9000_0000, 16'd0);    check_out("R7", 32'h8000_0000, 5'b11110);
    load_flags("R10", 5'b00000);
    do_op("R2", 2'd1, 32'h7000_0000, 32'h9000_0000, 16'd0);    check_out("R2", 32'h7FFF_FFFF, 5'b11100);
    load_flags("R10", 5'b00000);
    do_op("R2", 2'd1, 32'h9000_0000, 32'h7000_0000, 16'd0);    check_out("R2", 32'h8000_0000, 5'b10110);
    load_flags("R10", 5'b00000);
    do_op("R3", 2'd2, 32'h9000_0000, 32'h7000_0000, 16'd0);    check_out("R3", 32'h7FFF_FFFF, 5'b11100);
    load_flags("R10", 5'b00000);
    do_op("R3", 2'd2, 32'd1, 32'd2, 16'd0);                    check_out("R3", 32'd1, 5'b00000);
    do_op("R4", 2'd3, 32'h7FFF_FFFE, 32'd0, 16'hFFF6);         check_out("R4", 32'h7FFF_FFFF, 5'b11100);
    load_flags("R10", 5'b00000);
    do_op("R4", 2'd3, 32'h8000_0001, 32'd0, 16'd1);            check_out("R4", 32'h8000_0000, 5'b00010);
    do_op("R4", 2'd3, 32'h7FFF_FFFE, 32'd0, 16'hFFFF);         check_out("R4", 32'h7FFF_FFFF, 5'b01000);
    do_op("R8", 2'd1, 32'd5, 32'd5, 16'd0);                    check_out("R8", 32'd0, 5'b00001);
    do_op("R8", 2'd1, 32'd2, 32'd5, 16'd0);                    check_out("R8", 32'hFFFF_FFFD, 5'b01010);
    load_flags("R10", 5'b11111);                               check_out("R10", 32'hFFFF_FFFD, 5'b11111);

    // R10: load beats a clamping operation issued in the same cycle
    cur_req = "R10";
    flag_wr = 1'b1; flag_wr_data = 5'b00101;
    do_op("R10", 2'd0, 32'h7000_0000, 32'h7000_0000, 16'd0);
    flag_wr = 1'b0;
    check_out("R10", 32'h7FFF_FFFF, 5'b00101);

    // R11: idle cycles hold result and flags, no done pulse
    @(negedge clk);
    checks++;
    if (done !== 1'b0 || result !== 32'h7FFF_FFFF) begin
      errors++;
      $display("FAIL R11 idle: done %b result %h, expected 0 7fffffff", done, result);
    end
    // R11: done pulses only for one cycle after a request
    do_op("R11", 2'd0, 32'd0, 32'd0, 16'd0);
    checks++;
    if (done !== 1'b1) begin
      errors++;
      $display("FAIL R11 done: %b, expected 1", done);
    end

    repeat (2) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule